// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits in the instruction fetch stage and picks the next fetch address. It holds a small direct-mapped table in which every entry describes one branch seen before: its address tag, a 2-bit confidence counter and the target it last jumped to. In every cycle the current fetch PC is looked up combinationally. The block reports whether a branch entry matched, whether that branch is guessed taken, and the next PC. The next PC is the stored target on a taken guess, and the sequential address PC+4 in every other case.

A separate training port takes branches that the back end has resolved. Each one carries the branch PC, the actual direction and the actual target. A matching entry has its counter moved one step toward the outcome. A taken outcome also refreshes its target. A taken branch that does not match claims its slot. A not-taken branch that does not match leaves the table alone. Updates take effect at the next clock edge, so a lookup in the same cycle still sees the old table.

Top module: `btb_nextpc`

## Requirements
- R1: The table has 2^IDX_W entries (16 by default). Each entry is selected by PC bits [IDX_W+1:2] and matches only when it is valid and its stored tag equals PC bits [PC_W-1:IDX_W+2]. PC bits [1:0] play no part in matching.
- R2: On a miss, `pred_hit` and `pred_taken` are 0 and `pred_next_pc` equals `fetch_pc`+4, modulo 2^PC_W.
- R3: On a hit, `pred_taken` is 1 exactly when the entry's counter is 2 or 3. When `pred_taken` is 1, `pred_next_pc` is the stored target. When it is 0, `pred_next_pc` is `fetch_pc`+4.
- R4: When a resolved branch matches an entry, its counter rises by one on taken and falls by one on not-taken. The counter saturates at 3 and at 0.
- R5: When a resolved taken branch matches an entry, the stored target is replaced by `upd_target`.
- R6: A resolved taken branch that misses writes its slot: the slot becomes valid, takes the new tag and the new target, and its counter is set to 2. This also evicts any other branch held in that slot.
- R7: A resolved not-taken branch that misses changes nothing in the table.
- R8: A lookup and an update in the same cycle see the table as it was before that cycle's update. The update becomes visible after the next rising clock edge.
- R9: A synchronous reset, `rst` high at a rising edge, invalidates every entry. The resolved-branch PC must be word aligned, with bits [1:0] equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | Current fetch address |
| pred_hit | output | 1 | A valid entry matched `fetch_pc` |
| pred_taken | output | 1 | The matching branch is guessed taken |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |

## Verification
The bench builds the block with PC_W=12 and IDX_W=2, which gives four slots and an 8-bit tag. It draws fetch and branch PCs from only four tags over those four slots. Because the pool is so small, a few thousand cycles of pseudo-random traffic reach every slot in every counter state. The same traffic produces frequent evictions between aliasing branches and many cycles in which the lookup and the update address the same slot. An arithmetic model of the table in the bench supplies every expected output. Directed steps cover reset, saturation at both ends, and the low PC bits being ignored.

// File: rtl/btb_nextpc.sv
module btb_nextpc #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             u_hit;
  logic [1:0]       u_ctr_next;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign f_tag = fetch_pc[PC_W-1:IDX_W+2];
  assign u_idx = upd_pc[IDX_W+1:2];
  assign u_tag = upd_pc[PC_W-1:IDX_W+2];

  assign pred_hit     = vld[f_idx] && (tag_q[f_idx] == f_tag);
  assign pred_taken   = pred_hit && ctr_q[f_idx][1];
  assign pred_next_pc = pred_taken ? tgt_q[f_idx] : fetch_pc + PC_W'(4);

  assign u_hit = vld[u_idx] && (tag_q[u_idx] == u_tag);

  always_comb begin
    u_ctr_next = ctr_q[u_idx];
    if (upd_taken && ctr_q[u_idx] != 2'd3)
      u_ctr_next = ctr_q[u_idx] + 2'd1;
    else if (!upd_taken && ctr_q[u_idx] != 2'd0)
      u_ctr_next = ctr_q[u_idx] - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (upd_valid) begin
      if (u_hit) begin
        ctr_q[u_idx] <= u_ctr_next;
        if (upd_taken) tgt_q[u_idx] <= upd_target;
      end else if (upd_taken) begin
        vld[u_idx]   <= 1'b1;
        tag_q[u_idx] <= u_tag;
        ctr_q[u_idx] <= 2'd2;
        tgt_q[u_idx] <= upd_target;
      end
    end
  end

  p_miss_not_taken_r2: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> !pred_taken && pred_next_pc == fetch_pc + PC_W'(4));

  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);

  p_saturate_high_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && u_hit && upd_taken && ctr_q[u_idx] == 2'd3)
    |=> ctr_q[$past(u_idx)] == 2'd3);

  p_saturate_low_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && u_hit && !upd_taken && ctr_q[u_idx] == 2'd0)
    |=> ctr_q[$past(u_idx)] == 2'd0);

  p_alloc_weak_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !u_hit && upd_taken)
    |=> vld[$past(u_idx)] && ctr_q[$past(u_idx)] == 2'd2);

  p_no_alloc_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !u_hit && !upd_taken)
    |=> vld[$past(u_idx)] == $past(vld[u_idx]));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> vld == '0);

  p_aligned_update_r9: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> upd_pc[1:0] == 2'b00);
endmodule

// File: tb/sim_btb_nextpc.sv
module sim_btb_nextpc;
  localparam int PC_W = 12;
  localparam int IDX_W = 2;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pred_hit, pred_taken;
  logic [PC_W-1:0] pred_next_pc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic          mv   [N];
  logic [7:0]    mtag [N];
  logic [1:0]    mctr [N];
  logic [PC_W-1:0] mtgt [N];
  logic [15:0]   lfsr = 16'hACE1;

  always #10 clk = ~clk;

  btb_nextpc #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target));

  task automatic check_out(input string req);
    int i = int'(fetch_pc[3:2]);
    logic eh = mv[i] && mtag[i] == fetch_pc[11:4];
    logic et = eh && mctr[i] >= 2'd2;
    logic [PC_W-1:0] en = et ? mtgt[i] : fetch_pc + 12'd4;
    checks++;
    if (pred_hit !== eh || pred_taken !== et || pred_next_pc !== en) begin
      fails++;
      $display("FAIL %s pc=%h got hit=%b tk=%b npc=%h exp hit=%b tk=%b npc=%h",
               req, fetch_pc, pred_hit, pred_taken, pred_next_pc, eh, et, en);
    end
  endtask

  task automatic model_update();
    int i = int'(upd_pc[3:2]);
    if (!upd_valid) return;
    if (mv[i] && mtag[i] == upd_pc[11:4]) begin
      if (upd_taken) begin
        if (mctr[i] != 2'd3) mctr[i] = mctr[i] + 2'd1;
        mtgt[i] = upd_target;
      end else if (mctr[i] != 2'd0) mctr[i] = mctr[i] - 2'd1;
    end else if (upd_taken) begin
      mv[i] = 1'b1; mtag[i] = upd_pc[11:4]; mctr[i] = 2'd2; mtgt[i] = upd_target;
    end
  endtask

  // one update, model follows after the edge
  task automatic train(input logic [PC_W-1:0] pc, input logic t, input logic [PC_W-1:0] tg);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tg;
    @(posedge clk); #1;
    model_update();
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    @(negedge clk);
    fetch_pc = pc; #1;
    check_out(req);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mv[i] = 1'b0; mtag[i] = '0; mctr[i] = '0; mtgt[i] = '0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9: every slot empty after reset; R2: fall-through
    for (int p = 0; p < 16; p++) look(12'(p * 4), "R9");
    // R7: not-taken misses allocate nothing
    for (int s = 0; s < N; s++) begin
      train(12'(s * 4), 1'b0, 12'h100);
      look(12'(s * 4), "R7");
    end
    // R6 and R4: allocate, then walk counter to both ends
    for (int s = 0; s < N; s++) begin
      train(12'h040 + 12'(s * 4), 1'b1, 12'h800 + 12'(s * 16));
      look(12'h040 + 12'(s * 4), "R6");
      train(12'h040 + 12'(s * 4), 1'b1, 12'h900 + 12'(s * 16));
      look(12'h040 + 12'(s * 4), "R5");
      for (int k = 0; k < 3; k++) begin
        train(12'h040 + 12'(s * 4), 1'b1, 12'h900 + 12'(s * 16));
        look(12'h040 + 12'(s * 4), "R4");
      end
      for (int k = 0; k < 5; k++) begin
        train(12'h040 + 12'(s * 4), 1'b0, 12'h0);
        look(12'h040 + 12'(s * 4), "R3");
      end
      train(12'h040 + 12'(s * 4), 1'b1, 12'h700);
      look(12'h040 + 12'(s * 4), "R4");
    end
    // R1: low bits ignored, other tag misses
    for (int b = 0; b < 4; b++) look(12'h040 + 12'(b), "R1");
    look(12'h840, "R1");
    // R8 and random sweep: same-cycle lookups see old table
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      step_lfsr();
      fetch_pc = {6'b0, lfsr[3:0], 2'b00};
      upd_valid = lfsr[4];
      upd_pc = {6'b0, lfsr[8:5], 2'b00};
      upd_taken = lfsr[9];
      upd_target = {lfsr[15:10], lfsr[3:0], 2'b00};
      #1;
      check_out("R8");
      @(posedge clk); #1;
      model_update();
    end
    @(negedge clk); upd_valid = 1'b0;
    // R9: reset again invalidates everything
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    for (int p = 0; p < 16; p++) look(12'(p * 4), "R9");
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired got running exp finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule